// File: doc/BRIEF.md
# Single-Cycle 32-bit Arithmetic-Logic Unit

This block is the execute-stage arithmetic unit of a small RISC processor. It takes two operands and a 5-bit operation select, and in one cycle forms a sum or difference, any bitwise Boolean function of the two operands, a signed or unsigned comparison, or a barrel shift of up to 31 places. The arithmetic is purely combinational. A single output register stage sits behind it so that results and status can be sampled on a clock edge.

Four status flags (zero, carry, overflow, negative) always describe the shared adder. The adder subtracts for the subtract and compare operations and adds for every other code. The compare operations read their answer from those same adder signals.

Top module: `alu32_unit`

## Requirements
- R1: op_sel 5'h00 gives a+b and 5'h01 gives a-b, both modulo 2^32. Subtraction is formed as a + ~b + 1 on the one adder.
- R2: When op_sel[4] is 1, the low four bits form a truth-table code c, and result bit i equals c[{a[i], b[i]}]. Bit 1 of that index is a[i]. All sixteen codes are valid.
- R3: The flags come from the adder. The adder runs as a + ~b + 1 for op_sel 5'h01 to 5'h05 and as a + b for every other code. Carry is the bit out of position 31. Zero is set when the 32-bit adder sum is 0. Negative is bit 31 of the sum. Overflow is set when a and the adder's second input share a sign and the sum's sign differs from it.
- R4: The compare codes are 5'h02 equal, 5'h03 signed less-than, 5'h04 signed less-or-equal and 5'h05 unsigned less-than. Each returns 1 or 0 in bit 0, and bits 31..1 are zero.
- R5: The shift codes are 5'h06 left logical, 5'h07 right logical and 5'h08 right arithmetic. The amount is b[4:0] (0 to 31), and b[31:5] has no effect. An amount of 0 returns a unchanged.
- R6: A right logical shift fills the vacated upper bits with 0. A right arithmetic shift fills them with a[31]. A left shift fills the low bits with 0.
- R7: The unused codes 5'h09 to 5'h0F return a result of 0, and the flags still follow R3 in add mode.
- R8: result_q and the flags are registered, and each shows the value for the inputs present at the previous rising clock edge. While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand and shift amount |
| op_sel | input | 5 | Operation select |
| result_q | output | 32 | Registered result |
| flag_zero | output | 1 | Adder sum is zero |
| flag_carry | output | 1 | Adder carry out |
| flag_ovf | output | 1 | Adder signed overflow |
| flag_neg | output | 1 | Adder sum sign bit |

## Verification
The adder drives the flags on every cycle, so it works at the same time as the shifter or logic unit, which supplies the result. In those cycles the flags must follow a plain a+b even though the result port shows a shifted or Boolean value. Random vectors over every code, including shifts with junk in b[31:5], provoke this overlap. A bench model checks each cycle's result and flag set separately. The model computes the add-mode sum on its own and uses built-in signed and unsigned comparisons to check compare results.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
  localparam int OPW = 5;
  localparam logic [OPW-1:0] OP_ADD  = 5'h00;
  localparam logic [OPW-1:0] OP_SUB  = 5'h01;
  localparam logic [OPW-1:0] OP_SEQ  = 5'h02;
  localparam logic [OPW-1:0] OP_SLT  = 5'h03;
  localparam logic [OPW-1:0] OP_SLE  = 5'h04;
  localparam logic [OPW-1:0] OP_SLTU = 5'h05;
  localparam logic [OPW-1:0] OP_SLL  = 5'h06;
  localparam logic [OPW-1:0] OP_SRL  = 5'h07;
  localparam logic [OPW-1:0] OP_SRA  = 5'h08;

  typedef enum logic [1:0] {SH_LEFT = 2'd0, SH_RLOG = 2'd1, SH_RARI = 2'd2} shift_kind_e;

  typedef struct packed {
    logic zero;
    logic carry;
    logic ovf;
    logic neg;
  } alu_flags_t;

  function automatic logic uses_sub(input logic [OPW-1:0] op);
    return (op >= OP_SUB) && (op <= OP_SLTU);
  endfunction
endpackage

// File: rtl/alu32_adder.sv
module alu32_adder
  import alu32_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output alu_flags_t   flags
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  assign b_eff = sub ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign sum   = wide[W-1:0];

  always_comb begin
    flags.carry = wide[W];
    flags.zero  = (sum == '0);
    flags.neg   = sum[W-1];
    flags.ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu32_logic.sv
module alu32_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   tt_code,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = tt_code[{a[i], b[i]}];
  end
endmodule

// File: rtl/alu32_shifter.sv
module alu32_shifter
  import alu32_pkg::*;
#(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  input  shift_kind_e    kind,
  output logic [W-1:0]   dout
);
  logic [W-1:0] stage [SHW+1];
  logic [W-1:0] rev_in;
  logic [W-1:0] rev_out;
  logic         fill;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = din[W-1-i];
    assign rev_out[i] = stage[SHW][W-1-i];
  end

  assign fill     = (kind == SH_RARI) ? din[W-1] : 1'b0;
  assign stage[0] = (kind == SH_LEFT) ? rev_in : din;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt[k] ? {{STEP{fill}}, stage[k][W-1:STEP]} : stage[k];
  end

  assign dout = (kind == SH_LEFT) ? rev_out : stage[SHW];
endmodule

// File: rtl/alu32_unit.sv
module alu32_unit
  import alu32_pkg::*;
#(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   opnd_a,
  input  logic [W-1:0]   opnd_b,
  input  logic [OPW-1:0] op_sel,
  output logic [W-1:0]   result_q,
  output logic           flag_zero,
  output logic           flag_carry,
  output logic           flag_ovf,
  output logic           flag_neg
);
  logic [W-1:0] add_sum;
  logic [W-1:0] logic_y;
  logic [W-1:0] shift_y;
  alu_flags_t   add_flags;
  shift_kind_e  sh_kind;
  logic         is_logic;
  logic         cmp_lt_s;
  logic         cmp_lt_u;
  logic [W-1:0] result_d;

  alu32_adder #(.W(W)) u_adder (
    .a(opnd_a), .b(opnd_b), .sub(uses_sub(op_sel)), .sum(add_sum), .flags(add_flags)
  );

  alu32_logic #(.W(W)) u_logic (
    .a(opnd_a), .b(opnd_b), .tt_code(op_sel[3:0]), .y(logic_y)
  );

  always_comb begin
    unique case (op_sel)
      OP_SRL:  sh_kind = SH_RLOG;
      OP_SRA:  sh_kind = SH_RARI;
      default: sh_kind = SH_LEFT;
    endcase
  end

  alu32_shifter #(.W(W)) u_shift (
    .din(opnd_a), .amt(opnd_b[SHW-1:0]), .kind(sh_kind), .dout(shift_y)
  );

  assign is_logic = op_sel[OPW-1];
  assign cmp_lt_s = add_flags.neg ^ add_flags.ovf;
  assign cmp_lt_u = ~add_flags.carry;

  always_comb begin
    result_d = '0;
    if (is_logic) begin
      result_d = logic_y;
    end else begin
      case (op_sel)
        OP_ADD, OP_SUB:         result_d = add_sum;
        OP_SEQ:                 result_d[0] = add_flags.zero;
        OP_SLT:                 result_d[0] = cmp_lt_s;
        OP_SLE:                 result_d[0] = cmp_lt_s | add_flags.zero;
        OP_SLTU:                result_d[0] = cmp_lt_u;
        OP_SLL, OP_SRL, OP_SRA: result_d = shift_y;
        default:                result_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q   <= '0;
      flag_zero  <= 1'b0;
      flag_carry <= 1'b0;
      flag_ovf   <= 1'b0;
      flag_neg   <= 1'b0;
    end else begin
      result_q   <= result_d;
      flag_zero  <= add_flags.zero;
      flag_carry <= add_flags.carry;
      flag_ovf   <= add_flags.ovf;
      flag_neg   <= add_flags.neg;
    end
  end

  assert_cmp_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel >= OP_SEQ && op_sel <= OP_SLTU) |=> (result_q[W-1:1] == '0));

  assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_sel[OPW-1] && op_sel > OP_SRA) |=> (result_q == '0));

  assert_shift_zero_amt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_sel == OP_SLL || op_sel == OP_SRL || op_sel == OP_SRA) && opnd_b[SHW-1:0] == '0)
      |=> (result_q == $past(opnd_a)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_ADD && opnd_a[W-1] != opnd_b[W-1]) |=> !flag_ovf);

  assert_sub_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_SUB && opnd_a == opnd_b) |=> (flag_zero && flag_carry && result_q == '0));

  assert_eq_true_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_SEQ && opnd_a == opnd_b) |=> (result_q == 1));

  assert_logic_const_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 5'h10) |=> (result_q == '0));
endmodule

// File: tb/alu32_unit_tb_top.sv
`timescale 1ns/1ps
module alu32_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [4:0]  op_sel = '0;
  logic [31:0] result_q;
  logic        flag_zero, flag_carry, flag_ovf, flag_neg;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu32_unit dut_i (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel),
    .result_q(result_q), .flag_zero(flag_zero), .flag_carry(flag_carry),
    .flag_ovf(flag_ovf), .flag_neg(flag_neg)
  );

  function automatic logic [31:0] ref_result(input logic [4:0] op, input logic [31:0] a,
                                             input logic [31:0] b);
    logic [31:0] r;
    r = '0;
    if (op[4]) begin
      for (int i = 0; i < 32; i++) r[i] = op[{a[i], b[i]}];
    end else begin
      case (op)
        5'h00: r = a + b;
        5'h01: r = a - b;
        5'h02: r = {31'b0, a == b};
        5'h03: r = {31'b0, $signed(a) < $signed(b)};
        5'h04: r = {31'b0, $signed(a) <= $signed(b)};
        5'h05: r = {31'b0, a < b};
        5'h06: r = a << b[4:0];
        5'h07: r = a >> b[4:0];
        5'h08: r = $unsigned($signed(a) >>> b[4:0]);
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  function automatic logic [3:0] ref_flags(input logic [4:0] op, input logic [31:0] a,
                                           input logic [31:0] b);
    logic        sub;
    logic [32:0] w;
    logic [31:0] s;
    logic        v;
    sub = (op >= 5'h01 && op <= 5'h05);
    if (sub) w = {1'b0, a} - {1'b0, b} + 33'h1_0000_0000;
    else     w = {1'b0, a} + {1'b0, b};
    s = w[31:0];
    if (sub) v = (a[31] != b[31]) && (s[31] != a[31]);
    else     v = (a[31] == b[31]) && (s[31] != a[31]);
    return {s == 0, w[32], v, s[31]};
  endfunction

  function automatic string req_of(input logic [4:0] op);
    if (op[4]) return "R2";
    if (op <= 5'h01) return "R1";
    if (op <= 5'h05) return "R4";
    if (op == 5'h06) return "R5";
    if (op <= 5'h08) return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run_vec(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b);
    opnd_a = a;
    opnd_b = b;
    op_sel = op;
    @(negedge clk);
    check(req_of(op), result_q, ref_result(op, a, b));
    check("R3", {28'b0, flag_zero, flag_carry, flag_ovf, flag_neg}, {28'b0, ref_flags(op, a, b)});
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    opnd_a = 32'hFFFF_FFFF;
    opnd_b = 32'h1;
    op_sel = 5'h00;
    repeat (3) @(negedge clk);
    // R8: outputs held at zero in reset
    check("R8", result_q, 32'h0);
    check("R8", {28'b0, flag_zero, flag_carry, flag_ovf, flag_neg}, 32'h0);
    rst_n = 1'b1;
    // R8: one-cycle latency, then R1 carry wrap
    run_vec(5'h00, 32'hFFFF_FFFF, 32'h1);
    run_vec(5'h00, 32'h7FFF_FFFF, 32'h1);   // R3 overflow on add
    run_vec(5'h01, 32'h8000_0000, 32'h1);   // R3 overflow on sub
    run_vec(5'h01, 32'h1234_5678, 32'h1234_5678);
    run_vec(5'h02, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    run_vec(5'h03, 32'h8000_0000, 32'h7FFF_FFFF); // R4 signed extremes
    run_vec(5'h04, 32'h5, 32'h5);
    run_vec(5'h05, 32'h8000_0000, 32'h7FFF_FFFF);
    run_vec(5'h05, 32'h0, 32'h0);
    run_vec(5'h06, 32'h0000_0001, 32'h0000_001F);
    run_vec(5'h07, 32'h8000_0000, 32'hFFFF_FFDF); // R5 upper bits of b ignored
    run_vec(5'h08, 32'h8000_0000, 32'h0000_001F); // R6 sign fill
    run_vec(5'h08, 32'h7000_0000, 32'h0000_0004);
    run_vec(5'h06, 32'hA5A5_A5A5, 32'hFFFF_FFE0); // R5 amount 0
    run_vec(5'h09, 32'h1234_5678, 32'h1);         // R7 unused code
    run_vec(5'h0F, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    for (int c = 0; c < 16; c++) begin             // R2 every truth-table code
      run_vec({1'b1, c[3:0]}, 32'hFF00_F0CC, 32'hF0F0_AAAA);
    end
    // R1..R7 mixed random; flags checked alongside shift/logic results (R3)
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] op;
      op = 5'($urandom_range(0, 31));
      run_vec(op, $urandom, $urandom);
    end
    // R8: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R8", result_q, 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule